// File: doc/BRIEF.md
# Scan-Doubler Frame Store Arbiter

This block shares one external asynchronous SRAM between a slow digital video source and a line-doubling display path. It runs on a memory clock at exactly four times the source pixel rate, for example 28 MHz against a 7 MHz pixel clock. Each source pixel period is cut into four memory slots of one memory clock each, in a fixed order. Two of these slots store the incoming 12-bit pixel (4 bits each of red, green and blue). The other two slots fetch stored pixels, so the output path gets two pixels for every one that arrives.

Only visible pixels are stored. Pixels that arrive outside the data-enable window, during vertical sync, past the right edge of a line or below the last line take up no memory location and cause no write. The write address comes from a line/column counter. The read address is a free-running pointer that steps by one location per read slot, wraps at the end of the image, and is sent back to zero by a frame-start pulse from the output timing. Write strobes are confined to the low half of the memory clock inside a write slot. Output-enable is asserted only in read slots.

Top module: `sd_frame_arbiter`

## Requirements
- R1: Slots are counted from the memory clock edge that first samples the pixel clock high. The next cycle is slot 0, then come slots 1, 2 and 3. Slots 0 and 2 are write slots and slots 1 and 3 are read slots. If the pixel clock stalls, the order keeps cycling.
- R2: In a write slot that stores a pixel, chip-enable is low, output-enable is high and the data bus carries the captured pixel. Write-enable is low only while the memory clock is low. Both write slots of one pixel store the same value at the same address.
- R3: In every read slot, output-enable and chip-enable are low, write-enable is high, the block releases the data bus, and the address is the read pointer.
- R4: The read pointer advances by one after each read slot and wraps from H_ACT*V_ACT-1 to 0.
- R5: When out_fs is sampled high at a memory clock edge, the read pointer becomes 0, and this overrides the advance at that edge.
- R6: At the edge that ends each read slot, the bus value is loaded into rd_data. rd_valid is then high for exactly the following cycle.
- R7: A stored pixel goes to address line*H_ACT+col. The column steps on each active pixel, and the line steps (with the column cleared) on the first pixel whose data-enable is low after an active one.
- R8: A pixel with src_de low is not stored: write-enable and chip-enable stay high through both write slots.
- R9: Pixels at column H_ACT or beyond, or on line V_ACT or beyond, are not stored.
- R10: A pixel with src_vs high is not stored, even if src_de is high. It returns the line and column counters to 0.
- R11: During reset, write-enable, output-enable and chip-enable are high, rd_valid is low and rd_data is 0. The first pixel after reset is stored at address 0, and the first read after reset uses address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Memory clock, four times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_clk | input | 1 | Source pixel clock, sampled on mclk |
| src_vs | input | 1 | Source vertical sync, high for a frame start pixel |
| src_de | input | 1 | Source data enable, high for visible pixels |
| src_rgb | input | DW | Source pixel, 4 bits per colour |
| out_fs | input | 1 | Output frame start, resets the read pointer |
| sram_addr | output | AW | SRAM address |
| sram_dq | inout | DW | SRAM data bus |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| rd_data | output | DW | Pixel fetched in the last read slot |
| rd_valid | output | 1 | rd_data was loaded at the previous edge |

## Verification
The first stimulus is a reduced 8x4 frame whose lines have different lengths: full lines, a line that is too long, a short line, and a fifth line. These tell the column limit, the line limit and the line-advance rule apart by where each pixel does or does not land. A vertical-sync pixel with data-enable high and a rewrite of the first line separate counter reset from plain overwrite. A whole-frame readback, a wrap past the last location and a frame-start pulse placed in the middle of the stream tell a correctly wrapping, resettable read pointer apart from one that only counts. A reset in the middle of the run confirms that the write and read pointers both restart at zero.

// File: rtl/sd_frame_arbiter.sv
module sd_frame_arbiter #(
  parameter int DW    = 12,
  parameter int H_ACT = 640,
  parameter int V_ACT = 512,
  parameter int AW    = 19
) (
  input  logic          mclk,
  input  logic          rst_n,
  input  logic          pix_clk,
  input  logic          src_vs,
  input  logic          src_de,
  input  logic [DW-1:0] src_rgb,
  input  logic          out_fs,
  output logic [AW-1:0] sram_addr,
  inout  wire  [DW-1:0] sram_dq,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int FRAME = H_ACT * V_ACT;
  localparam int CW    = $clog2(H_ACT + 1);
  localparam int LW    = $clog2(V_ACT + 1);

  logic          pclk_q, pedge, wslot, in_win, de_q, cap_ok;
  logic [1:0]    phase;
  logic [CW-1:0] col;
  logic [LW-1:0] line;
  logic [AW-1:0] base, cap_addr, rd_ptr;
  logic [DW-1:0] cap_rgb;

  assign pedge  = pix_clk & ~pclk_q;
  assign wslot  = ~phase[0];
  assign in_win = (col < CW'(H_ACT)) && (line < LW'(V_ACT));

  // capture side: slot phase and line/column write counters
  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_q   <= 1'b0;
      phase    <= 2'd0;
      col      <= '0;
      line     <= '0;
      base     <= '0;
      de_q     <= 1'b0;
      cap_ok   <= 1'b0;
      cap_addr <= '0;
      cap_rgb  <= '0;
    end else begin
      pclk_q <= pix_clk;
      phase  <= pedge ? 2'd0 : phase + 2'd1;
      if (pedge) begin
        cap_rgb  <= src_rgb;
        cap_addr <= base + AW'(col);
        cap_ok   <= ~src_vs & src_de & in_win;
        de_q     <= src_de & ~src_vs;
        if (src_vs) begin
          col  <= '0;
          line <= '0;
          base <= '0;
        end else if (src_de) begin
          if (col < CW'(H_ACT)) col <= col + CW'(1);
        end else if (de_q) begin
          col <= '0;
          if (line < LW'(V_ACT)) begin
            line <= line + LW'(1);
            base <= base + AW'(H_ACT);
          end
        end
      end
    end
  end

  // fetch side: read pointer and returned pixel
  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else if (!wslot) begin
      rd_data  <= sram_dq;
      rd_valid <= 1'b1;
      if (out_fs || rd_ptr == AW'(FRAME - 1)) rd_ptr <= '0;
      else rd_ptr <= rd_ptr + AW'(1);
    end else begin
      rd_valid <= 1'b0;
      if (out_fs) rd_ptr <= '0;
    end
  end

  assign sram_addr = wslot ? cap_addr : rd_ptr;
  assign sram_oe_n = wslot;
  assign sram_ce_n = wslot & ~cap_ok;
  assign sram_we_n = ~(wslot & cap_ok & ~mclk);
  assign sram_dq   = (wslot & cap_ok) ? cap_rgb : {DW{1'bz}};
endmodule

// File: rtl/sd_frame_arbiter_chk.sv
module sd_frame_arbiter_chk #(
  parameter int AW    = 19,
  parameter int FRAME = 327680
) (
  input logic          mclk,
  input logic          rst_n,
  input logic          sram_ce_n,
  input logic          sram_we_n,
  input logic          sram_oe_n,
  input logic          rd_valid,
  input logic [AW-1:0] sram_addr
);
  // R3
  bus_excl_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !(!sram_oe_n && !sram_we_n));
  // R2
  we_ce_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n);
  // R9
  addr_range_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !sram_ce_n |-> (int'(sram_addr) < FRAME));
  // R6
  rdv_pulse_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  // R6
  rdv_src_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    rd_valid |-> $past(!sram_oe_n));
endmodule

bind sd_frame_arbiter sd_frame_arbiter_chk #(.AW(AW), .FRAME(H_ACT * V_ACT)) chk_i (
  .mclk(mclk), .rst_n(rst_n), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
  .sram_oe_n(sram_oe_n), .rd_valid(rd_valid), .sram_addr(sram_addr)
);

// File: tb/sd_frame_arbiter_tb_top.sv
module sd_frame_arbiter_tb_top;
  localparam int H = 8;
  localparam int V = 4;
  localparam int AW = 5;
  localparam int FRAME = H * V;
  localparam int NSEG = 18;

  // {fs, vs, de, count[7:0], seed[11:0]}
  localparam logic [22:0] SEG [NSEG] = '{
    {3'b010, 8'd1,  12'h000},
    {3'b000, 8'd2,  12'h000},
    {3'b001, 8'd8,  12'h100},
    {3'b000, 8'd2,  12'h000},
    {3'b001, 8'd10, 12'h200},
    {3'b000, 8'd3,  12'h000},
    {3'b001, 8'd5,  12'h300},
    {3'b000, 8'd1,  12'h000},
    {3'b001, 8'd8,  12'h400},
    {3'b000, 8'd1,  12'h000},
    {3'b001, 8'd4,  12'h500},
    {3'b000, 8'd1,  12'h000},
    {3'b011, 8'd2,  12'h600},
    {3'b001, 8'd3,  12'h700},
    {3'b000, 8'd1,  12'h000},
    {3'b100, 8'd16, 12'h000},
    {3'b000, 8'd3,  12'h000},
    {3'b101, 8'd2,  12'h800}
  };

  logic mclk = 1'b0, rst_n = 1'b0, pix_clk = 1'b0;
  logic src_vs = 1'b0, src_de = 1'b0, out_fs = 1'b0;
  logic [11:0] src_rgb = '0;
  logic [AW-1:0] sram_addr;
  wire  [11:0] sram_dq;
  logic sram_ce_n, sram_we_n, sram_oe_n, rd_valid;
  logic [11:0] rd_data;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [11:0] mem [FRAME];
  logic [11:0] shadow [FRAME];
  int m_col = 0, m_line = 0, rd_exp = 0;
  bit m_de_q = 0, pend_v = 0;
  logic [11:0] pend = '0;

  always #5 mclk = ~mclk;

  sd_frame_arbiter #(.DW(12), .H_ACT(H), .V_ACT(V), .AW(AW)) dut_i (
    .mclk(mclk), .rst_n(rst_n), .pix_clk(pix_clk), .src_vs(src_vs),
    .src_de(src_de), .src_rgb(src_rgb), .out_fs(out_fs),
    .sram_addr(sram_addr), .sram_dq(sram_dq), .sram_ce_n(sram_ce_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .rd_data(rd_data),
    .rd_valid(rd_valid)
  );

  assign sram_dq = (!sram_ce_n && !sram_oe_n && sram_we_n) ? mem[sram_addr] : 12'hzzz;
  always @(posedge sram_we_n) if (sram_ce_n === 1'b0) mem[sram_addr] <= sram_dq;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic wslot_chk(input bit ok, input int ea, input logic [11:0] rgb, input string tag);
    chk(sram_oe_n === 1'b1, "R1", "oe_n in write slot", 32'(sram_oe_n), 1);
    if (ok) begin
      chk(sram_ce_n === 1'b0 && sram_we_n === 1'b0, "R2", "ce_n/we_n",
          {sram_ce_n, sram_we_n}, 0);
      chk(sram_addr === AW'(ea), "R7", "write address", 32'(sram_addr), ea);
      chk(sram_dq === rgb, "R2", "write data", 32'(sram_dq), 32'(rgb));
    end else
      chk(sram_we_n === 1'b1 && sram_ce_n === 1'b1, tag, "no write",
          {sram_ce_n, sram_we_n}, 3);
  endtask

  task automatic rslot_chk(input string tag);
    chk(sram_oe_n === 1'b0 && sram_we_n === 1'b1 && sram_ce_n === 1'b0, "R3",
        "read slot controls", {sram_ce_n, sram_we_n, sram_oe_n}, 2);
    chk(sram_addr === AW'(rd_exp), tag, "read address", 32'(sram_addr), rd_exp);
    chk(rd_valid === 1'b0, "R6", "rd_valid in read slot", 32'(rd_valid), 0);
    pend = shadow[rd_exp];
    rd_exp = (rd_exp + 1) % FRAME;
    pend_v = 1;
  endtask

  task automatic rdata_chk();
    if (pend_v) begin
      chk(rd_valid === 1'b1, "R6", "rd_valid", 32'(rd_valid), 1);
      chk(rd_data === pend, "R6", "rd_data", 32'(rd_data), 32'(pend));
    end
  endtask

  task automatic pix(input bit fs, input bit vs, input bit de, input logic [11:0] rgb);
    bit ok;
    int ea;
    string tag;
    ok = !vs && de && (m_col < H) && (m_line < V);
    ea = m_line * H + m_col;
    tag = vs ? "R10" : (de ? "R9" : "R8");
    if (vs) begin m_col = 0; m_line = 0; end
    else if (de) begin if (m_col < H) m_col++; end
    else if (m_de_q) begin m_col = 0; if (m_line < V) m_line++; end
    m_de_q = de && !vs;
    pix_clk = 1'b1; src_vs = vs; src_de = de; src_rgb = rgb; out_fs = fs;
    @(posedge mclk); #7;
    out_fs = 1'b0;
    rdata_chk();
    if (fs) rd_exp = 0;
    wslot_chk(ok, ea, rgb, tag);
    if (ok) shadow[ea] = rgb;
    @(posedge mclk); #7;
    rslot_chk(fs ? "R5" : "R4");
    pix_clk = 1'b0;
    @(posedge mclk); #7;
    rdata_chk();
    wslot_chk(ok, ea, rgb, tag);
    @(posedge mclk); #7;
    rslot_chk("R4");
  endtask

  task automatic reset_chk();
    chk(sram_we_n === 1'b1 && sram_oe_n === 1'b1 && sram_ce_n === 1'b1, "R11",
        "controls in reset", {sram_ce_n, sram_we_n, sram_oe_n}, 7);
    chk(rd_valid === 1'b0 && rd_data === 12'h000, "R11", "read outputs in reset",
        {rd_valid, rd_data}, 0);
  endtask

  initial begin
    for (int i = 0; i < FRAME; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(posedge mclk);
    #7;
    reset_chk();
    rst_n = 1'b1;
    for (int s = 0; s < NSEG; s++) begin
      for (int k = 0; k < int'(SEG[s][19:12]); k++)
        pix(SEG[s][22] && k == 0, SEG[s][21], SEG[s][20], SEG[s][11:0] + 12'(k));
    end
    // mid-run reset: both pointers restart
    rst_n = 1'b0;
    repeat (2) @(posedge mclk);
    #7;
    reset_chk();
    rst_n = 1'b1;
    m_col = 0; m_line = 0; m_de_q = 0; rd_exp = 0; pend_v = 0;
    pix(1'b0, 1'b0, 1'b1, 12'h9ab);   // R11: lands at address 0
    pix(1'b0, 1'b0, 1'b1, 12'h9ac);
    pix(1'b0, 1'b0, 1'b0, 12'h000);
    pix(1'b0, 1'b0, 1'b0, 12'h000);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge mclk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule